// File: doc/BRIEF.md
# Two-Level Channel Interrupt Collector

This block gathers single-cycle event pulses from a set of framer channels and turns them into one active-low interrupt request for a processor. Each event pulse sets a sticky bit in one of several per-channel event registers. The block derives two summary views from these bits. The first is a per-channel source register that shows which of that channel's event registers are non-zero. The second is a top-level channel register that shows which channels are contributing to the interrupt. Each channel also has a single enable bit that masks all of its events at once.

A separate one-second rollover pulse sets its own sticky bit in the top-level register. That bit always shows the raw rollover state. It only reaches the interrupt line when its own enable bit is set.

Software reaches everything through a simple read/write port. On a read, the data appears on the cycle after the request. Reading an event register clears it, and reading the top-level register clears the rollover bit. Because the summaries are computed from the live event bits, an event bit that clears before software gets to it leaves no stale indication in either summary register.

Top module: `irq_tree`

## Requirements
- R1: After reset, all event bits, channel enables, the rollover bit and its enable are 0, `irq_n` is 1 and `rdata` is 0.
- R2: A 1 on `evt_i` bit `(c*NREG+k)*RW+b` sets bit b of event register k of channel c, and the bit stays set. The register is at address `16*(c+1)+2+k`. A read of that address returns the value held before the read and clears the register. An event arriving on the same cycle as the read stays set afterwards.
- R3: Bit k of channel c's source register (address `16*(c+1)+1`) is 1 exactly when event register k of that channel is non-zero. The bit drops as soon as that register clears.
- R4: Bit c of the top-level register (address 0x00) is 1 exactly when channel c's enable is 1 and any of its event registers is non-zero.
- R5: Bit 0 of channel control (address `16*(c+1)`, readable and writable) is the channel enable. When it is 0, the channel's events still set status bits, but they drive neither `irq_n` nor top-level bit c.
- R6: Bit 8 of the top-level register is set by `sec_tick_i` whatever its enable holds. A read of address 0x00 clears it, unless a tick arrives on the same cycle, in which case the tick wins.
- R7: The rollover bit drives `irq_n` only while bit 0 of the global control register (address 0x01, readable and writable) is 1.
- R8: `irq_n` is the registered inverse of the OR of all enabled channel summaries and the enabled rollover bit. It goes low one cycle after a source becomes pending and returns high one cycle after the last one clears.
- R9: A read of an unmapped address returns 0. Writes to any address other than the control registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NCH*NREG*RW | One-cycle event pulses, one per status bit |
| sec_tick_i | input | 1 | One-second counter rollover pulse |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| addr | input | 8 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid the cycle after `rd_en` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is a read that clears an event register on the same edge that a new event hits that register or the rollover bit. The summary bits and `irq_n` must then stay asserted, while the read data still shows the value from before the read. Directed steps line up a read and an event on the same clock, for both an event register and the top-level register. The random phase keeps reads frequent and events sparse, so pending bits often clear before software looks at them. It also toggles channel enables while events are pending.

// File: rtl/irq_tree.sv
module irq_tree #(
  parameter int NCH  = 4,
  parameter int NREG = 4,
  parameter int RW   = 8,
  parameter int DW   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH*NREG*RW-1:0]   evt_i,
  input  logic                     sec_tick_i,
  input  logic                     rd_en,
  input  logic                     wr_en,
  input  logic [7:0]               addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic                     irq_n
);
  localparam int NEV  = NCH*NREG*RW;
  localparam int SECB = 8;

  logic [NEV-1:0]      stat_q, clr_m;
  logic [NCH*NREG-1:0] src_v;
  logic [NCH-1:0]      ch_en, chan_sum;
  logic                sec_ie, sec_st, irq_q;
  logic [DW-1:0]       rd_mux;
  logic                top_rd;

  assign top_rd = rd_en && (addr == 8'h00);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar k = 0; k < NREG; k++) begin : g_reg
      logic hit;
      assign hit = rd_en && (addr == 8'((c+1)*16 + k + 2));
      assign clr_m[(c*NREG+k)*RW +: RW] = {RW{hit}};
      assign src_v[c*NREG+k] = |stat_q[(c*NREG+k)*RW +: RW];
    end
    assign chan_sum[c] = ch_en[c] & (|src_v[c*NREG +: NREG]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_m) | evt_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ch_en  <= '0;
      sec_ie <= 1'b0;
    end else if (wr_en) begin
      if (addr == 8'h01) sec_ie <= wdata[0];
      for (int c = 0; c < NCH; c++)
        if (addr == 8'((c+1)*16)) ch_en[c] <= wdata[0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          sec_st <= 1'b0;
    else if (sec_tick_i) sec_st <= 1'b1;
    else if (top_rd)     sec_st <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= (|chan_sum) | (sec_st & sec_ie);

  assign irq_n = ~irq_q;

  always_comb begin
    rd_mux = '0;
    if (addr == 8'h00) begin
      rd_mux[NCH-1:0] = chan_sum;
      rd_mux[SECB]    = sec_st;
    end else if (addr == 8'h01) begin
      rd_mux[0] = sec_ie;
    end
    for (int c = 0; c < NCH; c++) begin
      if (addr == 8'((c+1)*16))     rd_mux[0] = ch_en[c];
      if (addr == 8'((c+1)*16 + 1)) rd_mux[NREG-1:0] = src_v[c*NREG +: NREG];
      for (int k = 0; k < NREG; k++)
        if (addr == 8'((c+1)*16 + k + 2))
          rd_mux[RW-1:0] = stat_q[(c*NREG+k)*RW +: RW];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;

endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq_n,
  input logic           sec_ie,
  input logic           sec_st,
  input logic           sec_tick_i,
  input logic           rd_en,
  input logic [7:0]     addr,
  input logic [NCH-1:0] chan_sum
);
  p_sec_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick_i |=> sec_st);

  p_sec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_st && !(rd_en && addr == 8'h00)) |=> sec_st);

  p_sec_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 8'h00 && !sec_tick_i) |=> !sec_st);

  p_sec_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_ie && chan_sum == '0) |=> irq_n);

  p_chan_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_sum) |=> !irq_n);
endmodule

bind irq_tree irq_tree_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .sec_ie(sec_ie), .sec_st(sec_st),
  .sec_tick_i(sec_tick_i), .rd_en(rd_en), .addr(addr), .chan_sum(chan_sum)
);

// File: tb/irq_tree_test.sv
module irq_tree_test;
  localparam int NCH = 4, NREG = 4, RW = 8, DW = 16;
  localparam int NEV = NCH*NREG*RW;

  logic clk = 0, rst_n = 0;
  logic [NEV-1:0] evt_i = '0;
  logic sec_tick_i = 0, rd_en = 0, wr_en = 0;
  logic [7:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq_n;

  irq_tree #(.NCH(NCH), .NREG(NREG), .RW(RW), .DW(DW)) uut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  logic [NEV-1:0] m_stat = '0;
  logic [NCH-1:0] m_en = '0;
  logic m_ie = 0, m_sec = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic m_any(input int c);
    return |m_stat[c*NREG*RW +: NREG*RW];
  endfunction

  function automatic logic [DW-1:0] m_read(input logic [7:0] a);
    logic [DW-1:0] v = '0;
    if (a == 8'h00) begin
      for (int c = 0; c < NCH; c++) v[c] = m_en[c] & m_any(c);
      v[8] = m_sec;
    end else if (a == 8'h01) v[0] = m_ie;
    for (int c = 0; c < NCH; c++) begin
      if (a == 8'((c+1)*16)) v[0] = m_en[c];
      if (a == 8'((c+1)*16+1))
        for (int k = 0; k < NREG; k++) v[k] = |m_stat[(c*NREG+k)*RW +: RW];
      for (int k = 0; k < NREG; k++)
        if (a == 8'((c+1)*16+k+2)) v[RW-1:0] = m_stat[(c*NREG+k)*RW +: RW];
    end
    return v;
  endfunction

  function automatic logic m_irq();
    logic r = m_ie & m_sec;
    for (int c = 0; c < NCH; c++) r |= m_en[c] & m_any(c);
    return r;
  endfunction

  function automatic string tag(input logic [7:0] a);
    if (a == 8'h00) return "R4 R6";
    if (a == 8'h01) return "R7";
    if (a[7:4] >= 1 && a[7:4] <= NCH) begin
      if (a[3:0] == 0) return "R5";
      if (a[3:0] == 1) return "R3";
      if (a[3:0] < NREG+2) return "R2";
    end
    return "R9";
  endfunction

  task automatic step(input logic rd, wr, input logic [7:0] a, input logic [DW-1:0] wd,
                      input logic [NEV-1:0] ev, input logic tk);
    logic [DW-1:0] exp_rd;
    logic exp_irq;
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a; wdata = wd; evt_i = ev; sec_tick_i = tk;
    exp_rd = m_read(a);
    exp_irq = m_irq();
    @(posedge clk);
    if (rd) begin
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < NREG; k++)
          if (a == 8'((c+1)*16+k+2)) m_stat[(c*NREG+k)*RW +: RW] = '0;
      if (a == 8'h00) m_sec = 0;
    end
    m_stat |= ev;
    if (tk) m_sec = 1;
    if (wr) begin
      if (a == 8'h01) m_ie = wd[0];
      for (int c = 0; c < NCH; c++) if (a == 8'((c+1)*16)) m_en[c] = wd[0];
    end
    #1;
    chk("R8", DW'(irq_n), DW'(!exp_irq));
    if (rd) chk(tag(a), rdata, exp_rd);
    evt_i = '0; sec_tick_i = 0; rd_en = 0; wr_en = 0;
  endtask

  function automatic logic [NEV-1:0] onebit(input int i);
    logic [NEV-1:0] v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  initial begin
    #40000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    #10;
    chk("R1", DW'(irq_n), DW'(1));
    chk("R1", rdata, '0);
    rst_n = 1;
    step(1, 0, 8'h00, 0, '0, 0);
    chk("R1", rdata, '0);
    // R5: disabled channel sets status but no irq
    step(0, 0, 0, 0, onebit(3), 0);
    step(0, 0, 0, 0, '0, 0);
    step(1, 0, 8'h11, 0, '0, 0);
    chk("R5 irq masked", DW'(irq_n), DW'(1));
    step(0, 1, 8'h10, 16'h1, '0, 0);
    step(0, 0, 0, 0, '0, 0);
    chk("R8 enabled irq", DW'(irq_n), DW'(0));
    // R2: same-cycle read and event on reg 0 of ch0
    step(1, 0, 8'h12, 0, onebit(5), 0);
    chk("R2 old value", rdata, 16'h0008);
    step(1, 0, 8'h12, 0, '0, 0);
    chk("R2 event kept", rdata, 16'h0020);
    step(0, 0, 0, 0, '0, 0);
    chk("R8 release", DW'(irq_n), DW'(1));
    // R6/R7: tick with enable off, then same-cycle read+tick
    step(0, 0, 0, 0, '0, 1);
    step(0, 0, 0, 0, '0, 0);
    chk("R7 masked sec", DW'(irq_n), DW'(1));
    step(1, 0, 8'h00, 0, '0, 1);
    chk("R6 raw sec", rdata[8], 1'b1);
    step(1, 0, 8'h00, 0, '0, 0);
    chk("R6 tick wins", rdata[8], 1'b1);
    step(1, 0, 8'h00, 0, '0, 0);
    chk("R6 cleared", rdata[8], 1'b0);
    // R9: write to read-only and unmapped addresses
    step(0, 1, 8'h12, 16'hffff, '0, 0);
    step(0, 1, 8'h7f, 16'hffff, '0, 0);
    step(1, 0, 8'h7f, 0, '0, 0);
    step(1, 0, 8'h12, 0, '0, 0);
    for (int n = 0; n < 3000; n++) begin
      logic [NEV-1:0] ev = '0;
      logic [7:0] a;
      logic rd, wr;
      int r = $urandom_range(0, 9);
      if ($urandom_range(0, 5) == 0) ev = onebit($urandom_range(0, NEV-1));
      if ($urandom_range(0, 3) == 0) begin
        a = 8'(($urandom_range(1, NCH)) * 16 + $urandom_range(0, 5));
      end else a = 8'($urandom_range(0, 1));
      if (r == 0) a = 8'($urandom);
      rd = ($urandom_range(0, 2) == 0);
      wr = !rd && ($urandom_range(0, 7) == 0);
      step(rd, wr, a, 16'($urandom), ev, $urandom_range(0, 60) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule